// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is an SPI master that a processor drives through a small bus with word addresses. Software writes a byte into a transmit holding register. The controller moves that byte into a shift register and clocks it out most-significant bit first on `spi_sck` and `spi_mosi`. At the same time it shifts in the byte that the peripheral returns on `spi_miso`. A receive register holds the returned byte. Software reads a peripheral by writing a dummy byte, waiting until the status shows the transfer is finished, and then reading the receive register.

The serial clock comes from the system clock through a divider set at build time. Each SCK half-period lasts `HALF_DIV` system cycles, so the fastest SCK is half the system clock. A status word shows transmit readiness, receive availability, completion of all transmission, and two overrun conditions. A control word holds one interrupt enable for each condition, plus a bit that forces the slave select on. A separate select register also drives the active-low select output.

Top module: `spi_host_ctrl`

## Requirements
- R1: After synchronous reset, status reads 0x60 (only bit 5 "all sent" and bit 6 "transmit ready" set), `spi_ss_n`=1, `spi_sck`=0, `irq`=0 and `bus_rdata`=0.
- R2: Word offsets are fixed. Offset 0 is receive data, read in bits 7:0. Offset 1 is transmit data and reads 0. Offset 2 is status. Offset 3 is control. Offset 4 is reserved and reads 0. Offset 5 is select, bit 0. Offsets 6 and 7 read 0. The control readback holds only bits 3, 4, 6, 7, 8 and 10. `bus_rdata` is registered and updates on the edge where `bus_re` is sampled.
- R3: A frame is 8 bits, sent most-significant bit first, in mode 0. SCK idles low. MOSI changes only on SCK falling edges or when a frame is loaded. MISO is sampled on SCK rising edges.
- R4: One SCK period is 2*`HALF_DIV` system cycles. If the shifter is idle, a written byte is loaded on the following edge. The frame ends 16*`HALF_DIV` edges after the load.
- R5: Status bit 6 (transmit ready) is 1 while the holding register is empty. Status bit 5 (all sent) is 1 only when both the holding register and the shifter are empty.
- R6: Status bit 7 (receive available) is set when a frame completes. A read of offset 0 clears it, unless a frame completes on the same edge. The received byte is then readable at offset 0.
- R7: If a frame completes while bit 7 is already set, status bit 3 (receive overrun) is set. The new byte replaces the old one.
- R8: A transmit write while bit 6 is 0 sets status bit 4 (transmit overrun) and the byte is discarded.
- R9: Status bit 8 equals bit 3 OR bit 4. Any write to offset 2 clears bits 3 and 4. A receive overrun that arises on the same edge wins over the clear.
- R10: `irq` is the OR of each status bit 3, 4, 6, 7 and 8 ANDed with the control bit at the same position.
- R11: `spi_ss_n` is 0 when select bit 0 is 1 or control bit 10 is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after five corner cases. The first is a write that arrives while a byte is still in the holding register. A design that got this wrong would overwrite the queued byte instead of flagging transmit overrun. The second is a second frame completing before the first byte has been read. Here a faulty design would miss the receive overrun or keep the stale byte. The third is the gap between "transmit ready" returning and "all sent" rising. A design that watches only the holding register would report completion while bits are still shifting. The bench also checks the SCK period and bit order against a slave model, so a wrong divider count or LSB-first shifting shows up as a bad received byte. Finally, it checks that interrupts are masked per condition, including the summary error bit.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BUS_DW = 32;
  localparam int BUS_AW = 3;

  localparam logic [BUS_AW-1:0] OFS_RXD  = 3'd0;
  localparam logic [BUS_AW-1:0] OFS_TXD  = 3'd1;
  localparam logic [BUS_AW-1:0] OFS_STAT = 3'd2;
  localparam logic [BUS_AW-1:0] OFS_CTRL = 3'd3;
  localparam logic [BUS_AW-1:0] OFS_SEL  = 3'd5;

  localparam int B_RXOVR = 3;
  localparam int B_TXOVR = 4;
  localparam int B_IDLE  = 5;
  localparam int B_ROOM  = 6;
  localparam int B_AVAIL = 7;
  localparam int B_ERR   = 8;
  localparam int B_FSEL  = 10;

  typedef struct packed {
    logic en_rxovr;
    logic en_txovr;
    logic en_room;
    logic en_avail;
    logic en_err;
    logic force_sel;
  } ctrl_t;
endpackage

// File: rtl/spi_host_divider.sv
module spi_host_divider #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_data,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [FW-1:0] rx_byte
);
  localparam int EW = $clog2(2 * FW);
  localparam logic [EW-1:0] LAST = EW'(2 * FW - 1);

  logic [EW-1:0] edge_q;
  logic [FW-1:0] tx_sh, rx_sh;

  assign done    = busy && tick && sck && (edge_q == LAST);
  assign rx_byte = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      sck    <= 1'b0;
      edge_q <= '0;
      tx_sh  <= load_data;
      mosi   <= load_data[FW-1];
    end else if (busy && tick) begin
      edge_q <= edge_q + 1'b1;
      if (!sck) begin
        sck   <= 1'b1;
        rx_sh <= {rx_sh[FW-2:0], miso};
      end else begin
        sck <= 1'b0;
        if (edge_q == LAST) begin
          busy <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[FW-2:0], 1'b0};
          mosi  <= tx_sh[FW-2];
        end
      end
    end
  end

  // R3: clock rests low whenever no frame is in flight
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  // R3: data out never moves while the clock is high
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
  // R4: clock toggles only on a divider tick
  p_sck_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck) |-> $past(tick));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int FW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_ss_n,
  output logic              irq
);
  logic [FW-1:0] hold_q, rx_q, rx_byte;
  logic          hold_full, rrdy_q, roe_q, toe_q, sel_q;
  ctrl_t         ctl_q;
  logic          busy, tick, frame_done, load;
  logic          tx_wr, stat_wr, ctl_wr, sel_wr, rx_rd;
  logic          trdy, tmt, err;
  logic [BUS_DW-1:0] stat_word, ctl_word, rd_mux;

  assign tx_wr   = bus_we && (bus_addr == OFS_TXD);
  assign stat_wr = bus_we && (bus_addr == OFS_STAT);
  assign ctl_wr  = bus_we && (bus_addr == OFS_CTRL);
  assign sel_wr  = bus_we && (bus_addr == OFS_SEL);
  assign rx_rd   = bus_re && (bus_addr == OFS_RXD);
  assign load    = hold_full && !busy;

  assign trdy = !hold_full;
  assign tmt  = !hold_full && !busy;
  assign err  = roe_q || toe_q;

  spi_host_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  spi_host_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(hold_q), .tick(tick),
    .miso(spi_miso), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(frame_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      toe_q     <= 1'b0;
    end else begin
      if (tx_wr && !hold_full) begin
        hold_q    <= bus_wdata[FW-1:0];
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (tx_wr && hold_full) toe_q <= 1'b1;
      else if (stat_wr)       toe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= '0;
      rrdy_q <= 1'b0;
      roe_q  <= 1'b0;
    end else begin
      if (frame_done) begin
        rx_q   <= rx_byte;
        rrdy_q <= 1'b1;
      end else if (rx_rd) begin
        rrdy_q <= 1'b0;
      end
      if (frame_done && rrdy_q) roe_q <= 1'b1;
      else if (stat_wr)         roe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sel_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_q.en_rxovr  <= bus_wdata[B_RXOVR];
        ctl_q.en_txovr  <= bus_wdata[B_TXOVR];
        ctl_q.en_room   <= bus_wdata[B_ROOM];
        ctl_q.en_avail  <= bus_wdata[B_AVAIL];
        ctl_q.en_err    <= bus_wdata[B_ERR];
        ctl_q.force_sel <= bus_wdata[B_FSEL];
      end
      if (sel_wr) sel_q <= bus_wdata[0];
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[B_RXOVR] = roe_q;
    stat_word[B_TXOVR] = toe_q;
    stat_word[B_IDLE]  = tmt;
    stat_word[B_ROOM]  = trdy;
    stat_word[B_AVAIL] = rrdy_q;
    stat_word[B_ERR]   = err;
    ctl_word           = '0;
    ctl_word[B_RXOVR]  = ctl_q.en_rxovr;
    ctl_word[B_TXOVR]  = ctl_q.en_txovr;
    ctl_word[B_ROOM]   = ctl_q.en_room;
    ctl_word[B_AVAIL]  = ctl_q.en_avail;
    ctl_word[B_ERR]    = ctl_q.en_err;
    ctl_word[B_FSEL]   = ctl_q.force_sel;
    case (bus_addr)
      OFS_RXD:  rd_mux = {{(BUS_DW-FW){1'b0}}, rx_q};
      OFS_STAT: rd_mux = stat_word;
      OFS_CTRL: rd_mux = ctl_word;
      OFS_SEL:  rd_mux = {{(BUS_DW-1){1'b0}}, sel_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign spi_ss_n = !(sel_q || ctl_q.force_sel);
  assign irq = (ctl_q.en_rxovr && roe_q) || (ctl_q.en_txovr && toe_q) ||
               (ctl_q.en_room && trdy) || (ctl_q.en_avail && rrdy_q) ||
               (ctl_q.en_err && err);

  // R6: a finished frame always leaves a byte flagged as available
  p_rrdy_after_frame_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rrdy_q);
  // R6: reading the receive word retires the flag
  p_rx_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !frame_done) |=> !rrdy_q);
  // R8: writing into a full holding register flags overrun
  p_toe_on_full_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && hold_full) |=> toe_q);
  // R9: status write clears the receive overrun
  p_stat_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !frame_done) |=> (!roe_q && !toe_q));
  // R5: loading the shifter frees the holding register
  p_load_frees_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !tx_wr) |=> (!hold_full && busy));
endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
  localparam int HALF_T = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_ss_n, irq;
  logic        spi_miso;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  spi_host_ctrl #(.HALF_DIV(HALF_T), .FW(8)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'hA5 ^ 8'(n * 37);
  endfunction

  // behavioural reference model
  logic        m_hold = 0, m_busy = 0, m_rrdy = 0, m_roe = 0, m_toe = 0, m_sel = 0;
  logic [5:0]  m_ctl = '0;   // rxovr, txovr, room, avail, err, fsel
  logic [7:0]  m_rx = '0;
  logic [31:0] m_rdata = '0;
  string       m_tag = "R1";
  int          m_cnt = 0, m_frames = 0;
  logic [7:0]  exp_q[$];

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[3] = m_roe; s[4] = m_toe; s[5] = !m_hold && !m_busy;
    s[6] = !m_hold; s[7] = m_rrdy; s[8] = m_roe || m_toe;
    return s;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_hold <= 0; m_busy <= 0; m_rrdy <= 0; m_roe <= 0; m_toe <= 0;
      m_sel <= 0; m_ctl <= '0; m_rx <= '0; m_rdata <= '0; m_cnt <= 0;
    end else begin
      logic done;
      done = m_busy && (m_cnt == 1);
      if (m_busy) begin
        if (done) m_busy <= 0;
        m_cnt <= m_cnt - 1;
      end else if (m_hold) begin
        m_busy <= 1; m_cnt <= 16 * HALF_T; m_hold <= 0;
      end
      if (bus_we && bus_addr == 3'd1) begin
        if (m_hold) m_toe <= 1;
        else begin m_hold <= 1; exp_q.push_back(bus_wdata[7:0]); end
      end else if (bus_we && bus_addr == 3'd2) m_toe <= 0;
      if (done) begin
        m_rx <= pat(m_frames); m_frames <= m_frames + 1; m_rrdy <= 1;
      end else if (bus_re && bus_addr == 3'd0) m_rrdy <= 0;
      if (done && m_rrdy) m_roe <= 1;
      else if (bus_we && bus_addr == 3'd2) m_roe <= 0;
      if (bus_we && bus_addr == 3'd3)
        m_ctl <= {bus_wdata[3], bus_wdata[4], bus_wdata[6], bus_wdata[7], bus_wdata[8], bus_wdata[10]};
      if (bus_we && bus_addr == 3'd5) m_sel <= bus_wdata[0];
      if (bus_re) begin
        case (bus_addr)
          3'd0: begin m_rdata <= {24'd0, m_rx}; m_tag <= "R6"; end
          3'd2: begin m_rdata <= m_status(); m_tag <= "R5"; end
          3'd3: begin
            m_rdata <= (32'(m_ctl[5]) << 3) | (32'(m_ctl[4]) << 4) | (32'(m_ctl[3]) << 6) |
                       (32'(m_ctl[2]) << 7) | (32'(m_ctl[1]) << 8) | (32'(m_ctl[0]) << 10);
            m_tag <= "R2";
          end
          3'd5: begin m_rdata <= {31'd0, m_sel}; m_tag <= "R2"; end
          default: begin m_rdata <= '0; m_tag <= "R2"; end
        endcase
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [31:0] s;
      logic ei;
      s = m_status();
      ei = (m_ctl[5] && s[3]) || (m_ctl[4] && s[4]) || (m_ctl[3] && s[6]) ||
           (m_ctl[2] && s[7]) || (m_ctl[1] && s[8]);
      chk(m_tag, bus_rdata, m_rdata);
      chk("R10", 32'(irq), 32'(ei));
      chk("R11", 32'(spi_ss_n), 32'(!(m_sel || m_ctl[0])));
      if (!m_busy) chk("R3", 32'(spi_sck), 32'd0);
    end
  end

  // mode-0 slave model
  int s_rc = 0, s_n = 0, s_bit = 7, last_rise = 0;
  logic [7:0] s_cap = '0;
  initial spi_miso = pat(0)[7];

  always @(posedge spi_sck) begin
    if (s_rc > 0) chk("R4", 32'(cyc - last_rise), 32'(2 * HALF_T));
    last_rise = cyc;
    s_cap = {s_cap[6:0], spi_mosi};
    s_rc++;
    if (s_rc == 8) begin
      if (exp_q.size() == 0) chk("R3", 32'(s_cap), 32'hFFFF_FFFF);
      else chk("R3", 32'(s_cap), 32'(exp_q.pop_front()));
    end
  end

  always @(negedge spi_sck) begin
    if (s_rc == 8) begin s_rc = 0; s_n++; s_bit = 7; end
    else s_bit--;
    spi_miso = pat(s_n)[s_bit];
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_hold || m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", 32'(spi_ss_n), 32'd1);
    chk("R1", 32'(spi_sck), 32'd0);
    chk("R1", 32'(irq), 32'd0);
    chk("R1", bus_rdata, 32'd0);
    rd(3'd2, v); chk("R1", v, 32'h60);

    wr(3'd5, 32'd1);
    wr(3'd3, 32'h80);                 // interrupt on receive available
    wr(3'd1, 32'h3C);
    rd(3'd2, v); chk("R5", v[5], 1'b0);  // shifting, not all sent
    wait_idle();
    chk("R10", 32'(irq), 32'd1);
    rd(3'd0, v); chk("R6", v, 32'(pat(0)));
    rd(3'd2, v); chk("R6", v[7], 1'b0);

    wr(3'd1, 32'hA1);
    wr(3'd1, 32'h5E);
    wr(3'd1, 32'hFF);                 // holding register full: dropped
    rd(3'd2, v); chk("R8", v[4], 1'b1); chk("R9", v[8], 1'b1);
    wait_idle();
    rd(3'd2, v); chk("R7", v[3], 1'b1);
    rd(3'd0, v); chk("R7", v, 32'(pat(2)));
    wr(3'd3, 32'h100);                // summary error only
    chk("R10", 32'(irq), 32'd1);
    wr(3'd2, 32'd0);
    rd(3'd2, v); chk("R9", v, 32'h60);
    chk("R10", 32'(irq), 32'd0);

    wr(3'd5, 32'd0);
    chk("R11", 32'(spi_ss_n), 32'd1);
    wr(3'd3, 32'hFFFF_FFFF);
    chk("R11", 32'(spi_ss_n), 32'd0);
    rd(3'd3, v); chk("R2", v, 32'h5D8);
    rd(3'd4, v); chk("R2", v, 32'd0);
    rd(3'd1, v); chk("R2", v, 32'd0);
    rd(3'd7, v); chk("R2", v, 32'd0);
    wr(3'd3, 32'd0);
    for (int i = 0; i < 4; i++) begin
      wr(3'd1, 32'(8'h11 * (i + 1)));
      wait_idle();
      rd(3'd0, v); chk("R6", v, 32'(pat(3 + i)));
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule